// File: doc/BRIEF.md
# Four-Slice Ripple Arithmetic Logic Unit

This block computes one of eight operations on two 4-bit operands. It is built from identical one-bit slices. In each slice, a 4-to-1 operand selector conditions the second operand before it reaches a full adder. A 4-to-1 logic selector forms the bitwise result. A 2-to-1 output selector picks between the adder sum and the logic result.

The carry enters at the least significant slice and ripples upward, one slice at a time. The seed carry and the operand conditioning are what turn the single adder into add, subtract, increment or decrement.

Operands and the operation code arrive as one beat on a valid/ready input. The result and carry leave as one beat on a valid/ready output.
- With the default `REG_OUT = 1`, the result is held in an output register. An input beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the register is empty or the downstream side takes the held beat in the same cycle. While `out_valid` is high and `out_ready` is low, the held beat does not change.
- With `REG_OUT = 0`, the path is purely combinational and the handshake signals pass straight through.

Top module: `alu4_slice_top`

## Requirements
- R1: Opcode 000 (add) gives result = (A + B) mod 16 and carry = bit 4 of A + B.
- R2: Opcode 001 (subtract) gives result = (A + ~B + 1) mod 16 and carry = 1 exactly when A >= B, taking both as unsigned.
- R3: Opcode 010 (increment) gives result = (A + 1) mod 16 and carry = 1 only when A = 1111. B has no effect on either output.
- R4: Opcode 011 (decrement) gives result = (A + 1111) mod 16 and carry = 1 unless A = 0000. B has no effect on either output.
- R5: Opcodes 100, 101, 110 and 111 give the bitwise AND, OR, XOR and XNOR of A and B respectively, and carry is 0 for all four.
- R6: With REG_OUT = 1, an input beat accepted at a clock edge appears on `out_res`/`out_carry`, with `out_valid` high, right after that same edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_res`, `out_carry` and `out_valid` hold their values and `in_ready` is low.
- R8: When the held beat is taken and no new input is valid, `out_valid` is low after that edge.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat may be accepted |
| in_op | input | 3 | Operation code |
| in_a | input | 4 | Operand A |
| in_b | input | 4 | Operand B |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result beat |
| out_res | output | 4 | Result |
| out_carry | output | 1 | Final ripple carry, 0 for logic opcodes |

## Verification
Every result and carry is due one edge after its input beat is accepted. The bench drives each beat at a falling edge and lets one rising edge pass. It then compares at the next falling edge, which is the first point where the registered output is settled and away from any edge.

During a stall, the bench samples at each falling edge while `out_ready` stays low. On release, the waiting beat is due after the single edge at which the held beat drains. The empty state is due one edge after that.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_INC  = 3'b010,
    OP_DEC  = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_XNOR = 3'b111
  } alu_op_e;

  // Operand conditioning codes carried on op[1:0] for arithmetic opcodes
  localparam logic [1:0] SEL_PASS = 2'b00;
  localparam logic [1:0] SEL_INV  = 2'b01;
  localparam logic [1:0] SEL_ZERO = 2'b10;
  localparam logic [1:0] SEL_ONE  = 2'b11;

  function automatic logic op_is_logic(input logic [2:0] op);
    return op[2];
  endfunction

  // Carry seed: 1 for subtract and increment, 0 for add and decrement
  function automatic logic op_carry_seed(input logic [2:0] op);
    return (~op[2]) & (op[1] ^ op[0]);
  endfunction

endpackage

// File: rtl/alu4_opnd_sel.sv
module alu4_opnd_sel
  import alu4_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       b_in,
  output logic       b_out
);
  always_comb begin
    unique case (sel)
      SEL_PASS: b_out = b_in;
      SEL_INV:  b_out = ~b_in;
      SEL_ZERO: b_out = 1'b0;
      default:  b_out = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu4_full_add.sv
module alu4_full_add (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  assign p  = x ^ y;
  assign s  = p ^ ci;
  assign co = (x & y) | (p & ci);
endmodule

// File: rtl/alu4_bit_slice.sv
module alu4_bit_slice (
  input  logic [2:0] op,
  input  logic       a,
  input  logic       b,
  input  logic       ci,
  output logic       res,
  output logic       co
);
  logic b_cond;
  logic sum;
  logic lg;

  alu4_opnd_sel u_sel (
    .sel   (op[1:0]),
    .b_in  (b),
    .b_out (b_cond)
  );

  alu4_full_add u_fa (
    .x  (a),
    .y  (b_cond),
    .ci (ci),
    .s  (sum),
    .co (co)
  );

  always_comb begin
    unique case (op[1:0])
      2'b00:   lg = a & b;
      2'b01:   lg = a | b;
      2'b10:   lg = a ^ b;
      default: lg = ~(a ^ b);
    endcase
  end

  assign res = op[2] ? lg : sum;
endmodule

// File: rtl/alu4_slice_top.sv
module alu4_slice_top
  import alu4_pkg::*;
#(
  parameter int unsigned WIDTH   = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_res,
  output logic             out_carry
);
  localparam int unsigned NCARRY = WIDTH + 1;

  logic [NCARRY-1:0] carry;
  logic [WIDTH-1:0]  res_c;
  logic              carry_c;

  assign carry[0] = op_carry_seed(in_op);

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu4_bit_slice u_slice (
      .op  (in_op),
      .a   (in_a[i]),
      .b   (in_b[i]),
      .ci  (carry[i]),
      .res (res_c[i]),
      .co  (carry[i+1])
    );
  end

  assign carry_c = op_is_logic(in_op) ? 1'b0 : carry[WIDTH];

  if (REG_OUT) begin : g_reg
    logic             vld_q;
    logic [WIDTH-1:0] res_q;
    logic             cy_q;
    logic             take;

    assign in_ready = ~vld_q | out_ready;
    assign take     = in_valid & in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
        cy_q  <= 1'b0;
      end else begin
        if (in_ready) vld_q <= in_valid;
        if (take) begin
          res_q <= res_c;
          cy_q  <= carry_c;
        end
      end
    end

    assign out_valid = vld_q;
    assign out_res   = res_q;
    assign out_carry = cy_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_res   = res_c;
    assign out_carry = carry_c;
  end
endmodule

// File: rtl/alu4_slice_chk.sv
module alu4_slice_chk #(
  parameter int unsigned WIDTH   = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_res,
  input logic             out_carry
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  if (REG_OUT) begin : g_seq
    // R6: an accepted beat is presented after the edge
    assert_accept_presents_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

    // R7: stalled output holds
    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_carry)));

    // R8: drained with no new beat leaves the output empty
    assert_drain_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !in_valid) |=> !out_valid);

    // R5: logic opcodes never produce a carry
    assert_logic_no_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_op[2]) |=> !out_carry);

    // R3: increment result follows operand A only
    assert_inc_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_op == 3'b010) |=> (out_res == $past(in_a) + ONE));

    // R4: decrement result follows operand A only
    assert_dec_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_op == 3'b011) |=> (out_res == $past(in_a) - ONE));
  end else begin : g_cmb
    always_comb begin
      if (rst_n && in_valid && in_op[2])
        assert_logic_no_carry_R5: assert (!out_carry);
    end
  end
endmodule

bind alu4_slice_top alu4_slice_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) chk_i (.*);

// File: tb/alu4_slice_top_tb_top.sv
module alu4_slice_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [2:0]   in_op;
  logic [W-1:0] in_a;
  logic [W-1:0] in_b;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] out_res;
  logic         out_carry;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu4_slice_top #(.WIDTH(W), .REG_OUT(1'b1)) dut_i (
    .clk, .rst_n, .in_valid, .in_ready, .in_op, .in_a, .in_b,
    .out_valid, .out_ready, .out_res, .out_carry
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W:0] ref_calc(input logic [2:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    logic [W:0] s;
    case (op)
      3'b000: s = {1'b0, a} + {1'b0, b};
      3'b001: s = {1'b0, a} + {1'b0, ~b} + 1;
      3'b010: s = {1'b0, a} + 1;
      3'b011: s = {1'b0, a} + {1'b0, {W{1'b1}}};
      3'b100: s = {1'b0, a & b};
      3'b101: s = {1'b0, a | b};
      3'b110: s = {1'b0, a ^ b};
      default: s = {1'b0, ~(a ^ b)};
    endcase
    return s;
  endfunction

  // Apply one beat and check it one edge later
  task automatic apply_one(input string req, input logic [2:0] op, input logic [W-1:0] a,
                           input logic [W-1:0] b);
    logic [W:0] e;
    e = ref_calc(op, a, b);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    chk(req, "out_valid", int'(out_valid), 1);
    chk(req, $sformatf("res op%0d a%0d b%0d", op, a, b), int'(out_res), int'(e[W-1:0]));
    chk(req, $sformatf("carry op%0d a%0d b%0d", op, a, b), int'(out_carry), int'(e[W]));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "out_valid after reset", int'(out_valid), 0);
    chk("R9", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_sweep(input string req, input logic [2:0] op);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        apply_one(req, op, W'(a), W'(b));
  endtask

  // R3/R4: B must not matter; compare against the B = 0 result
  task automatic t_b_ignored(input string req, input logic [2:0] op);
    logic [W:0] e;
    for (int a = 0; a < 16; a++) begin
      e = ref_calc(op, W'(a), '0);
      for (int b = 0; b < 16; b += 5) begin
        in_valid = 1'b1; in_op = op; in_a = W'(a); in_b = W'(b);
        @(negedge clk);
        chk(req, "B-independent result", int'(out_res), int'(e[W-1:0]));
        chk(req, "B-independent carry", int'(out_carry), int'(e[W]));
      end
    end
  endtask

  task automatic t_stall_drain();
    logic [W:0] e1, e2;
    e1 = ref_calc(3'b000, 4'd9, 4'd8);
    e2 = ref_calc(3'b001, 4'd3, 4'd5);
    out_ready = 1'b1;
    in_valid = 1'b1; in_op = 3'b000; in_a = 4'd9; in_b = 4'd8;
    @(negedge clk);
    chk("R6", "first beat res", int'(out_res), int'(e1[W-1:0]));
    out_ready = 1'b0;
    in_op = 3'b001; in_a = 4'd3; in_b = 4'd5;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7", "held out_valid", int'(out_valid), 1);
      chk("R7", "held res", int'(out_res), int'(e1[W-1:0]));
      chk("R7", "held carry", int'(out_carry), int'(e1[W]));
      chk("R7", "in_ready low", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R6", "waiting beat res", int'(out_res), int'(e2[W-1:0]));
    chk("R6", "waiting beat carry", int'(out_carry), int'(e2[W]));
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8", "out_valid after drain", int'(out_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk);
    t_sweep("R1", 3'b000);
    t_sweep("R2", 3'b001);
    t_sweep("R3", 3'b010);
    t_sweep("R4", 3'b011);
    t_sweep("R5", 3'b100);
    t_sweep("R5", 3'b101);
    t_sweep("R5", 3'b110);
    t_sweep("R5", 3'b111);
    t_b_ignored("R3", 3'b010);
    t_b_ignored("R4", 3'b011);
    t_stall_drain();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule